// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block holds five 16-bit compare values and checks them against a 16-bit count supplied by an external free-running counter. Each time that counter takes a new value (after a prescaled increment or after software loads it), the owner of the counter pulses a strobe. On that cycle, every enabled channel whose compare value equals the count sets its flag. Because the comparison happens only on strobe cycles, a channel matches once per counter value and not once per bus cycle, whatever the prescale ratio.

Software reaches the block over a byte-wide register bus. Each compare value is loaded as a high byte and a low byte. An enable register holds one bit per channel. A flag register reports the channels that have matched and is cleared by writing ones. The interrupt request is active while any flagged channel is also enabled.

Top module: `oc5_unit`

## Requirements
- R1: After reset, all compare values, the enable register and the flag register read as zero, `flag_o` is 0 and `irq_o` is low.
- R2: The high byte of the compare value for channel k (k = 1..5) is at address 2(k-1) and its low byte is at address 2(k-1)+1. Each byte reads back the value last written to it. Writes to addresses above 11 change no register, and reads of those addresses return 0.
- R3: The enable register is at address 10. Channel 1 is enabled by bit 7, channel 2 by bit 6, and so on down to channel 5 at bit 3. Bits 2..0 read as 0 and enable nothing.
- R4: On a cycle where `cnt_new` is high, a channel's flag sets when its enable bit is 1 and its compare value equals `cnt_value`. `flag_o[k-1]` is the flag of channel k. In the flag register at address 11, channel 1 is at bit 7 and channel 5 is at bit 3. Bits 2..0 read as 0.
- R5: While all five enable bits are 0, no flag sets for any count.
- R6: When `cnt_new` is low, no flag sets, even if a compare value equals `cnt_value`.
- R7: Writing the flag register clears each flag whose bit is written as 1 and leaves each flag whose bit is written as 0. If a match and a clear hit the same flag in the same cycle, the match wins and the flag stays set.
- R8: `irq_o` is high exactly when some channel has both its flag and its enable bit set. A flag whose enable bit has been cleared stays set but does not drive `irq_o`.
- R9: A compare byte written on one clock edge is the value used for a strobe on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cnt_value | input | 16 | Current value of the external counter |
| cnt_new | input | 1 | Pulses when the counter has taken a new value |
| flag_o | output | 5 | Channel flags, with bit 0 for channel 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted compare byte or enable bit shows up as a missing flag, or a flag on the wrong channel, on the clock edge that follows the strobe carrying the matching count. A corrupted compare byte also shows up at once when its address is read back. A flag that sets without a strobe, or that survives a write-one clear, shows on `flag_o` and `irq_o` one edge later. The test vectors pair counts with enable patterns so that each channel and each bit position is checked alone, together with its neighbours, and while masked.

// File: rtl/oc5_unit.sv
module oc5_unit #(
  parameter int ADDR_W    = 4,
  parameter int NCH       = 5,
  parameter int CW        = 16,
  parameter int MASK_ADDR = 10,
  parameter int FLAG_ADDR = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [CW-1:0]     cnt_value,
  input  logic              cnt_new,
  output logic [NCH-1:0]    flag_o,
  output logic              irq_o
);
  localparam int HB = CW - 8;

  logic [CW-1:0]  cmp_q [NCH];
  logic [NCH-1:0] en_q, flg_q, hit, clr;

  wire flag_wr = bus_wr && bus_addr == ADDR_W'(FLAG_ADDR);
  wire mask_wr = bus_wr && bus_addr == ADDR_W'(MASK_ADDR);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit[c] = cnt_new && en_q[c] && cmp_q[c] == cnt_value;
    assign clr[c] = flag_wr && bus_wdata[7-c];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cmp_q[c] <= '0;
        en_q[c]  <= 1'b0;
        flg_q[c] <= 1'b0;
      end else begin
        if (bus_wr && bus_addr == ADDR_W'(2*c))   cmp_q[c][CW-1:8] <= bus_wdata[HB-1:0];
        if (bus_wr && bus_addr == ADDR_W'(2*c+1)) cmp_q[c][7:0]    <= bus_wdata;
        if (mask_wr) en_q[c] <= bus_wdata[7-c];
        flg_q[c] <= hit[c] | (flg_q[c] & ~clr[c]);
      end

    AST_SET_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flg_q[c]) |-> $past(cnt_new && en_q[c] && cmp_q[c] == cnt_value)); // R4
    AST_CLEAR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && bus_wdata[7-c] && !cnt_new) |=> !flg_q[c]); // R7
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(2*c))   bus_rdata = 8'(cmp_q[c][CW-1:8]);
      if (bus_addr == ADDR_W'(2*c+1)) bus_rdata = cmp_q[c][7:0];
      if (bus_addr == ADDR_W'(MASK_ADDR)) bus_rdata[7-c] = en_q[c];
      if (bus_addr == ADDR_W'(FLAG_ADDR)) bus_rdata[7-c] = flg_q[c];
    end
  end

  assign flag_o = flg_q;
  assign irq_o  = |(flg_q & en_q);

  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> ((flg_q & ~$past(flg_q)) == '0)); // R5
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_new && !flag_wr) |=> $stable(flg_q)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o != '0)); // R8
endmodule

// File: tb/oc5_unit_tb.sv
module oc5_unit_tb;
  logic        clk = 0, rst_n = 0, bus_wr = 0, cnt_new = 0;
  logic [3:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0, bus_rdata;
  logic [15:0] cnt_value = 0;
  logic [4:0]  flag_o;
  logic        irq_o;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #5 clk = ~clk;

  oc5_unit u_dut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
                  .cnt_value, .cnt_new, .flag_o, .irq_o);

  // {enable byte, count, expected flag_o}
  localparam logic [28:0] VEC [9] = '{
    {8'hF8, 16'h1234, 5'b01001},
    {8'h80, 16'h1234, 5'b00001},
    {8'h10, 16'h1234, 5'b01000},
    {8'hF8, 16'h00FF, 5'b00010},
    {8'hF8, 16'hFF00, 5'b00100},
    {8'hF8, 16'hFFFF, 5'b10000},
    {8'h00, 16'h1234, 5'b00000},
    {8'h07, 16'hFFFF, 5'b00000},
    {8'hF8, 16'h0000, 5'b00000}
  };
  localparam logic [15:0] CMP [5] = '{16'h1234, 16'h00FF, 16'hFF00, 16'h1234, 16'hFFFF};

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic wr, logic [3:0] a, logic [7:0] d, logic st, logic [15:0] cv);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_new = st; cnt_value = cv;
    @(negedge clk);
    bus_wr = 0; cnt_new = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cyc(1, a, d, 0, cnt_value);
  endtask

  task automatic strobe(logic [15:0] cv);
    cyc(0, bus_addr, 0, 1, cv);
  endtask

  task automatic rd(logic [3:0] a);
    bus_addr = a; #1 rv = bus_rdata;
  endtask

  function automatic logic [7:0] fl2reg(logic [4:0] f);
    logic [7:0] r = 0;
    for (int i = 0; i < 5; i++) r[7-i] = f[i];
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag_o", 16'(flag_o), 0);
    chk("R1 irq_o", 16'(irq_o), 0);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a)); chk("R1 reg", 16'(rv), 0);
    end

    // R2 compare byte map and readback
    for (int c = 0; c < 5; c++) begin
      wr(4'(2*c), CMP[c][15:8]);
      wr(4'(2*c+1), CMP[c][7:0]);
    end
    for (int c = 0; c < 5; c++) begin
      rd(4'(2*c));   chk("R2 high byte", 16'(rv), 16'(CMP[c][15:8]));
      rd(4'(2*c+1)); chk("R2 low byte", 16'(rv), 16'(CMP[c][7:0]));
    end
    wr(4'd12, 8'hAA);
    wr(4'd15, 8'h55);
    rd(4'd12); chk("R2 unmapped read", 16'(rv), 0);
    rd(4'd0);  chk("R2 unmapped write ignored", 16'(rv), 16'h12);

    // R3 enable bits 2..0 read as zero
    wr(4'd10, 8'hFF);
    rd(4'd10); chk("R3 enable readback", 16'(rv), 16'hF8);

    // vector table: R4 R5 R3
    foreach (VEC[i]) begin
      wr(4'd11, 8'hF8);
      wr(4'd10, VEC[i][28:21]);
      strobe(VEC[i][20:5]);
      chk("R4 flag_o vector", 16'(flag_o), 16'(VEC[i][4:0]));
      chk("R8 irq_o vector", 16'(irq_o), 16'(VEC[i][4:0] != 0));
      rd(4'd11); chk("R4 flag register", 16'(rv), 16'(fl2reg(VEC[i][4:0])));
    end

    // R6 equal count without strobe sets nothing
    wr(4'd11, 8'hF8);
    wr(4'd10, 8'hF8);
    cyc(0, 4'd0, 0, 0, 16'h1234);
    cyc(0, 4'd0, 0, 0, 16'h1234);
    chk("R6 no strobe", 16'(flag_o), 0);

    // R7 write-one clear, zero leaves
    strobe(16'h1234);                 // ch1 and ch4
    wr(4'd11, 8'h00);
    chk("R7 zero write keeps", 16'(flag_o), 16'b01001);
    wr(4'd11, 8'h80);                 // clear ch1 only
    chk("R7 one clears", 16'(flag_o), 16'b01000);
    // match and clear together: match wins
    cyc(1, 4'd11, 8'h10, 1, 16'h1234);
    chk("R7 set beats clear", 16'(flag_o), 16'b01001);

    // R8 masked flag stays but no irq
    wr(4'd10, 8'h00);
    chk("R8 flag kept", 16'(flag_o), 16'b01001);
    chk("R8 irq masked", 16'(irq_o), 0);
    wr(4'd10, 8'h10);
    chk("R8 irq re-enabled", 16'(irq_o), 1);

    // R9 compare write then strobe next edge
    wr(4'd11, 8'hF8);
    wr(4'd10, 8'h20);                 // channel 3 only
    cyc(1, 4'd5, 8'h77, 0, 0);        // low byte of ch3 -> FF77
    strobe(16'hFF77);
    chk("R9 new compare used", 16'(flag_o), 16'b00100);
    wr(4'd11, 8'hF8);
    strobe(16'hFF00);
    chk("R9 old compare gone", 16'(flag_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule